// File: doc/BRIEF.md
# GPIO Interrupt Type Detector

This block watches a bank of general-purpose input pins and raises an interrupt request when a pin meets its programmed condition. Each pin has a 3-bit type code that selects one of five conditions: a level (high or low), a rising edge, a falling edge, or any edge. The codes for all pins are packed into one read/write configuration register. Each pin passes through a two-flop synchroniser, so pins may change at any time with respect to the clock.

The per-pin results form a status vector. Level-type bits follow the synchronised pin. Edge-type bits are sticky until software clears them by writing a one. A per-pin enable register masks the status, and the masked bits are ORed into a single interrupt output. Software reaches the configuration, enable and status registers through a plain synchronous register port. The port has a read latency of one cycle.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, the configuration, enable and status registers read 0x00000000 and `irq_o` is low. Every pin therefore starts in active-high level mode.
- R2: Address 0 is the configuration register. Pin n owns bits 3n+2:3n, and bits 31:24 always read zero. Reads return the register selected by the address of the previous cycle.
- R3: Type 000 (active-high level): the pin's status bit is 1 while the synchronised input is 1. It follows the pin two clock edges after the pin changes.
- R4: Type 001 (active-low level): the pin's status bit is 1 while the synchronised input is 0.
- R5: Type 010 (rising edge): a 0-to-1 change of the synchronised input sets the status bit. A falling change or a steady level does not set it.
- R6: Type 011 (falling edge): a 1-to-0 change of the synchronised input sets the status bit. A rising change does not set it.
- R7: Any type code with bit 2 set (1xx) selects any-edge detection: either change sets the status bit, whatever the two low bits hold.
- R8: Address 2 is the status register, one bit per pin with pin n at bit n. In edge mode, a status bit stays set until a write to address 2 carries a 1 in that bit position; a 0 leaves it set. Writes have no effect on level-mode bits.
- R9: If an edge event and a clearing write on the same pin fall in the same cycle, the status bit ends up set.
- R10: A configuration write that changes a pin's type code clears that pin's sticky bit. It also reloads the pin's edge history with the current synchronised value, so a pin already held high reports no rising edge after it is switched to rising mode.
- R11: Address 1 is the enable register, pin n at bit n. `irq_o` is high exactly when some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_i | input | NUM_PINS | Asynchronous general-purpose inputs |
| reg_addr_i | input | 2 | Register select: 0 config, 1 enable, 2 status, 3 reads zero |
| reg_we_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, registered, one cycle after the address |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A corrupted edge-history flop shows up on the ports as a phantom or missing status bit. Such a bit can be read back within three cycles of the pin change, and `irq_o` shows it in the same cycle once the pin is enabled. A corrupted type field shows up as a wrong level response. The field layout is checked by programming a single middle field and observing which status bit lights. Sticky and clear priority faults surface at the next status read after a write that lands in the same cycle as an edge.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  localparam int TYPE_W = 3;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CFG  = 2'd0,
    SEL_EN   = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [2:0] {
    MODE_LVL_HI,
    MODE_LVL_LO,
    MODE_RISE,
    MODE_FALL,
    MODE_ANY
  } pin_mode_e;

  // Bit 2 dominates: when set, the two low bits are don't-care.
  function automatic pin_mode_e decode_type(input logic [TYPE_W-1:0] code);
    pin_mode_e m;
    if (code[2]) begin
      m = MODE_ANY;
    end else begin
      case (code[1:0])
        2'b00:   m = MODE_LVL_HI;
        2'b01:   m = MODE_LVL_LO;
        2'b10:   m = MODE_RISE;
        default: m = MODE_FALL;
      endcase
    end
    return m;
  endfunction

  function automatic logic is_edge_mode(input pin_mode_e m);
    return (m == MODE_RISE) || (m == MODE_FALL) || (m == MODE_ANY);
  endfunction

endpackage

// File: rtl/gpio_irq_rst_sync.sv
`timescale 1ns/1ps
module gpio_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = din_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_comb begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_pin_detect.sv
`timescale 1ns/1ps
module gpio_irq_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic              type_load_i,
  input  logic              clr_i,
  output logic              status_o,
  output logic              sticky_o,
  output logic              hit_o
);

  pin_mode_e mode;
  logic      edge_mode;
  logic      prev_q;
  logic      prev_d;
  logic      prev_en;
  logic      sticky_q;
  logic      sticky_d;
  logic      rise;
  logic      fall;
  logic      hit;

  always_comb begin
    mode      = decode_type(type_i);
    edge_mode = is_edge_mode(mode);
    // History only runs in edge mode; a type change reloads it.
    prev_en   = edge_mode | type_load_i;
    prev_d    = sync_i;
    rise      = sync_i & ~prev_q;
    fall      = ~sync_i & prev_q;
    case (mode)
      MODE_RISE: hit = rise;
      MODE_FALL: hit = fall;
      MODE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  // Priority: type change, then new event, then software clear.
  always_comb begin
    if (type_load_i) begin
      sticky_d = 1'b0;
    end else if (hit) begin
      sticky_d = 1'b1;
    end else if (clr_i) begin
      sticky_d = 1'b0;
    end else begin
      sticky_d = sticky_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
    end else if (prev_en) begin
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= 1'b0;
    end else begin
      sticky_q <= sticky_d;
    end
  end

  always_comb begin
    case (mode)
      MODE_LVL_HI: status_o = sync_i;
      MODE_LVL_LO: status_o = ~sync_i;
      default:     status_o = sticky_q;
    endcase
  end

  assign sticky_o = sticky_q;
  assign hit_o    = hit;

endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic                       reg_we_i,
  input  logic [DATA_W-1:0]          reg_wdata_i,
  input  logic [NUM_PINS-1:0]        status_i,
  output logic [DATA_W-1:0]          reg_rdata_o,
  output logic [NUM_PINS*TYPE_W-1:0] cfg_o,
  output logic [NUM_PINS-1:0]        en_o,
  output logic [NUM_PINS-1:0]        type_load_o,
  output logic [NUM_PINS-1:0]        clr_o
);

  localparam int CFG_W = NUM_PINS * TYPE_W;

  reg_sel_e          sel;
  logic              wr_cfg;
  logic              wr_en;
  logic              wr_stat;
  logic [CFG_W-1:0]  cfg_q;
  logic [CFG_W-1:0]  cfg_d;
  logic [NUM_PINS-1:0] en_q;
  logic [NUM_PINS-1:0] en_d;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;
  logic              unused_wdata;

  always_comb begin
    sel     = reg_sel_e'(reg_addr_i);
    wr_cfg  = reg_we_i && (sel == SEL_CFG);
    wr_en   = reg_we_i && (sel == SEL_EN);
    wr_stat = reg_we_i && (sel == SEL_STAT);
    cfg_d   = wr_cfg ? reg_wdata_i[CFG_W-1:0] : cfg_q;
    en_d    = wr_en  ? reg_wdata_i[NUM_PINS-1:0] : en_q;
    clr_o   = wr_stat ? reg_wdata_i[NUM_PINS-1:0] : '0;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_load
    always_comb begin
      type_load_o[p] = wr_cfg &&
        (reg_wdata_i[p*TYPE_W +: TYPE_W] != cfg_q[p*TYPE_W +: TYPE_W]);
    end
  end

  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_CFG:  rdata_d[CFG_W-1:0]    = cfg_q;
      SEL_EN:   rdata_d[NUM_PINS-1:0] = en_q;
      SEL_STAT: rdata_d[NUM_PINS-1:0] = status_i;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      en_q    <= '0;
      rdata_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      en_q    <= en_d;
      rdata_q <= rdata_d;
    end
  end

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:CFG_W];
  assign cfg_o       = cfg_q;
  assign en_o        = en_q;
  assign reg_rdata_o = rdata_q;

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [1:0]          reg_addr_i,
  input  logic                reg_we_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                irq_o
);

  localparam int CFG_W = NUM_PINS * TYPE_W;

  logic                rst_q_n;
  logic [NUM_PINS-1:0] sync_vec;
  logic [CFG_W-1:0]    cfg_vec;
  logic [NUM_PINS-1:0] en_vec;
  logic [NUM_PINS-1:0] load_vec;
  logic [NUM_PINS-1:0] clr_vec;
  logic [NUM_PINS-1:0] status_vec;
  logic [NUM_PINS-1:0] sticky_vec;
  logic [NUM_PINS-1:0] hit_vec;

  gpio_irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_q_n)
  );

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_q_n),
    .din_i (pin_i),
    .dout_o(sync_vec)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_q_n),
    .reg_addr_i (reg_addr_i),
    .reg_we_i   (reg_we_i),
    .reg_wdata_i(reg_wdata_i),
    .status_i   (status_vec),
    .reg_rdata_o(reg_rdata_o),
    .cfg_o      (cfg_vec),
    .en_o       (en_vec),
    .type_load_o(load_vec),
    .clr_o      (clr_vec)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_irq_pin_detect u_pin (
      .clk_i      (clk_i),
      .rst_ni     (rst_q_n),
      .sync_i     (sync_vec[p]),
      .type_i     (cfg_vec[p*TYPE_W +: TYPE_W]),
      .type_load_i(load_vec[p]),
      .clr_i      (clr_vec[p]),
      .status_o   (status_vec[p]),
      .sticky_o   (sticky_vec[p]),
      .hit_o      (hit_vec[p])
    );
  end

  always_comb begin
    irq_o = |(status_vec & en_vec);
  end

endmodule

// File: rtl/gpio_irq_detect_chk.sv
`timescale 1ns/1ps
module gpio_irq_detect_chk #(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 32
) (
  input logic                  clk_i,
  input logic                  rst_q_n,
  input logic [NUM_PINS-1:0]   pin_i,
  input logic [DATA_W-1:0]     reg_rdata_o,
  input logic                  irq_o,
  input logic [NUM_PINS*3-1:0] cfg_vec,
  input logic [NUM_PINS-1:0]   en_vec,
  input logic [NUM_PINS-1:0]   status_vec,
  input logic [NUM_PINS-1:0]   sticky_vec,
  input logic [NUM_PINS-1:0]   hit_vec,
  input logic [NUM_PINS-1:0]   load_vec,
  input logic [NUM_PINS-1:0]   clr_vec
);

  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_q_n) begin
    if (!rst_q_n) begin
      age_q <= '0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    reg_rdata_o[DATA_W-1:NUM_PINS*3] == '0);

  assert_irq_masked_R11: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (en_vec == '0) |-> !irq_o);

  assert_irq_raised_R11: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    ((sticky_vec & en_vec) != '0) |-> irq_o);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
    assert_level_follow_R3: assert property (@(posedge clk_i) disable iff (!rst_q_n)
      (age_q == 2'd3 && cfg_vec[p*3 +: 3] == 3'b000) |-> status_vec[p] == $past(pin_i[p], 2));

    assert_sticky_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_q_n)
      $fell(sticky_vec[p]) |-> ($past(clr_vec[p]) || $past(load_vec[p])));

    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_q_n)
      (hit_vec[p] && clr_vec[p] && !load_vec[p]) |=> sticky_vec[p]);

    assert_load_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_q_n)
      load_vec[p] |=> !sticky_vec[p]);
  end

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_q_n    (rst_q_n),
  .pin_i      (pin_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .cfg_vec    (cfg_vec),
  .en_vec     (en_vec),
  .status_vec (status_vec),
  .sticky_vec (sticky_vec),
  .hit_vec    (hit_vec),
  .load_vec   (load_vec),
  .clr_vec    (clr_vec)
);

// File: tb/gpio_irq_detect_tb.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb;

  localparam int NP = 8;
  localparam int DW = 32;
  localparam int NV = 14;

  // {type[2:0], pin_before, pin_after, expected_status}
  localparam logic [5:0] VEC [0:NV-1] = '{
    6'b000_0_1_1, 6'b000_1_0_0, 6'b001_0_0_1, 6'b001_0_1_0,
    6'b010_0_1_1, 6'b010_1_0_0, 6'b011_1_0_1, 6'b011_0_1_0,
    6'b100_0_1_1, 6'b101_1_0_1, 6'b110_0_0_0, 6'b111_1_0_1,
    6'b010_1_1_0, 6'b011_0_0_0
  };

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] pin;
  logic [1:0]    addr;
  logic          we;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] rv;

  gpio_irq_detect #(.NUM_PINS(NP), .DATA_W(DW)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pin_i      (pin),
    .reg_addr_i (addr),
    .reg_we_i   (we),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .irq_o      (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic set_pins(input logic [NP-1:0] v);
    @(negedge clk);
    pin = v;
  endtask

  function automatic string req_of(input logic [2:0] t);
    if (t[2])          return "R7";
    if (t[1:0] == 2'd0) return "R3";
    if (t[1:0] == 2'd1) return "R4";
    if (t[1:0] == 2'd2) return "R5";
    return "R6";
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin = '0; addr = '0; we = 1'b0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    settle();

    // R1: reset state
    rd(2'd0, rv); chk("R1 cfg", rv, 32'h0);
    rd(2'd1, rv); chk("R1 en", rv, 32'h0);
    rd(2'd2, rv); chk("R1 status", rv, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // Vector table over all type codes
    for (int i = 0; i < NV; i++) begin
      int j;
      logic [2:0] t;
      j = i % NP;
      t = VEC[i][5:3];
      set_pins('0);
      wr(2'd0, 32'h0);
      settle();
      wr(2'd0, DW'(t) << (3 * j));
      set_pins(NP'(VEC[i][2]) << j);
      settle();
      wr(2'd2, {DW{1'b1}});
      settle();
      set_pins(NP'(VEC[i][1]) << j);
      settle();
      rd(2'd2, rv);
      chk(req_of(t), rv, DW'(VEC[i][0]) << j);
    end

    // R2: layout and reserved bits
    set_pins('0);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, rv); chk("R2 reserved", rv, 32'h00FF_FFFF);
    wr(2'd0, 32'h0000_8000);
    settle();
    rd(2'd0, rv); chk("R2 readback", rv, 32'h0000_8000);
    rd(2'd2, rv); chk("R2 pin5 field", rv, 32'h0000_0020);
    rd(2'd3, rv); chk("R2 unmapped", rv, 32'h0);

    // R8: sticky edge bit and write-one-to-clear; level bit unaffected
    wr(2'd0, 32'h0000_0002);
    set_pins(8'h02);
    settle();
    wr(2'd2, 32'hFF);
    settle();
    set_pins(8'h03);
    settle();
    rd(2'd2, rv); chk("R5 rise set", rv, 32'h3);
    set_pins(8'h02);
    settle();
    rd(2'd2, rv); chk("R8 sticky after pin drop", rv, 32'h3);
    wr(2'd2, 32'h0);
    settle();
    rd(2'd2, rv); chk("R8 zero write keeps", rv, 32'h3);
    wr(2'd2, 32'hFF);
    settle();
    rd(2'd2, rv); chk("R8 one write clears edge, level kept", rv, 32'h2);

    // R9: edge event and clear in the same cycle
    set_pins(8'h00);
    settle();
    wr(2'd2, 32'hFF);
    settle();
    @(negedge clk) pin = 8'h01;
    @(negedge clk);
    @(negedge clk);
    we = 1'b1; addr = 2'd2; wdata = 32'h1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
    rd(2'd2, rv); chk("R9 set wins", rv, 32'h1);

    // R10: type change reloads history and clears sticky
    wr(2'd0, 32'h0);
    set_pins(8'h01);
    settle();
    wr(2'd0, 32'h2);
    settle();
    rd(2'd2, rv); chk("R10 no spurious rise", rv, 32'h0);
    set_pins(8'h00);
    settle();
    set_pins(8'h01);
    settle();
    rd(2'd2, rv); chk("R10 real rise", rv, 32'h1);
    wr(2'd0, 32'h3);
    settle();
    rd(2'd2, rv); chk("R10 change clears", rv, 32'h0);

    // R11: enable masking of irq
    wr(2'd0, 32'h0);
    set_pins(8'h04);
    settle();
    #1 chk("R11 masked", {31'b0, irq}, 32'h0);
    wr(2'd1, 32'h04);
    rd(2'd1, rv); chk("R11 enable readback", rv, 32'h04);
    #1 chk("R11 enabled", {31'b0, irq}, 32'h1);
    wr(2'd1, 32'h08);
    @(posedge clk);
    #1 chk("R11 other enable", {31'b0, irq}, 32'h0);
    set_pins(8'h0C);
    settle();
    #1 chk("R11 pin3 raises", {31'b0, irq}, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule